// File: doc/BRIEF.md
# Dual-Pair I/Q Slice Deframer

This block sits behind a narrow receive interface. That interface presents one 6-bit data slice on every clock together with a single frame bit. Two complex sample pairs are spread over a repeating group of eight slices. While the frame bit is high, the slices belong to pair 1. While it is low, they belong to pair 2. Within each half, the high half of I comes first, then the high half of Q, then the low half of I, then the low half of Q. The block reassembles the four 12-bit values. It presents all four at once, with a one-cycle valid strobe per complete group.

A small state machine tracks the slot position. It has three states. `ST_HUNT` is entered at reset. `ST_PAIR1` covers slots 0 to 3 and `ST_PAIR2` covers slots 4 to 7. A 2-bit beat counter gives the position inside a pair state. The transitions are named as follows:
- **lock**: `ST_HUNT` to `ST_PAIR1`, on the first rising frame edge.
- **rise-resync**: any locked state to `ST_PAIR1` at beat 1, taken when a rising edge lands the current word in slot 0.
- **fall-resync**: any locked state to `ST_PAIR2` at beat 1, taken when a falling edge lands the current word in slot 4.
- **advance**: beat plus one, within the same state.
- **half-wrap**: `ST_PAIR1` beat 3 to `ST_PAIR2` beat 0.
- **group-wrap**: `ST_PAIR2` beat 3 to `ST_PAIR1` beat 0.

A frame level that disagrees with the current state, when no edge is present, sets a sticky alignment error.

Top module: `iq_deframer_dual`

## Requirements
- R1: While the frame bit is high, four consecutive words are stored as pair 1 slices in this order: I1 bits 11:6, Q1 bits 11:6, I1 bits 5:0, Q1 bits 5:0.
- R2: While the frame bit is low, four consecutive words are stored as pair 2 slices in this order: I2 bits 11:6, Q2 bits 11:6, I2 bits 5:0, Q2 bits 5:0.
- R3: Each 12-bit output is its high slice concatenated above its low slice.
- R4: `grp_valid` is high for exactly one cycle, the cycle after the clock edge that captures the eighth slice. All four outputs take that group's values at that same edge.
- R5: Between valid strobes, all four sample outputs hold their values.
- R6: A rising frame edge places the current word in slot 0, and a falling edge places it in slot 4. After an extra word, the next complete group is still decoded correctly.
- R7: A group that lacks any slot since its rising edge produces no valid strobe, and the outputs keep the previous group.
- R8: `align_err` rises when, with no frame edge, the frame level contradicts the expected half. It then stays high until reset. Frame edges never set it.
- R9: Reset is asynchronous and active high, and clears the outputs, `grp_valid` and `align_err`. After reset, words are discarded until a rising frame edge. A frame bit that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Asynchronous reset, active high |
| lane_slice | input | 6 | Data slice of the current word |
| frame_bit | input | 1 | Frame indicator of the current word |
| i1_out | output | 12 | Reassembled I of pair 1 |
| q1_out | output | 12 | Reassembled Q of pair 1 |
| i2_out | output | 12 | Reassembled I of pair 2 |
| q2_out | output | 12 | Reassembled Q of pair 2 |
| grp_valid | output | 1 | One-cycle strobe per complete group |
| align_err | output | 1 | Sticky alignment error |

## Verification
A wrong beat or state shows up within one group: a slice lands in the wrong output field, or the strobe arrives early, late or not at all, eight words after the rising edge. A corrupted fill record shows the same way. It either lets a partial group through, with stale fields visible at once, or suppresses a full one, so the outputs stay at the previous group. A fault in the sticky flag appears on the first mismatched word, or as a flag that drops during later clean groups.

// File: rtl/iqdf_pkg.sv
package iqdf_pkg;
    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int SLOTS  = 2 * BEATS;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_PAIR1 = 2'd1,
        ST_PAIR2 = 2'd2
    } seq_state_t;
endpackage

// File: rtl/iqdf_edge_detect.sv
module iqdf_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic frame_in,
    output logic rise,
    output logic fall
);
    // Held high at reset so a level already high at release is no edge.
    logic prev_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= frame_in;
    end

    always_comb begin
        rise = frame_in & ~prev_q;
        fall = ~frame_in & prev_q;
    end
endmodule

// File: rtl/iqdf_slot_seq.sv
module iqdf_slot_seq
    import iqdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              level,
    output logic              cap_en,
    output logic [SLOT_W-1:0] cap_slot,
    output logic              align_err
);
    seq_state_t        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              cap_half;
    logic [BEAT_W-1:0] cap_beat;
    logic              mismatch;
    logic              err_q;

    // Capture decision for the current word
    always_comb begin
        cap_en   = 1'b0;
        cap_half = 1'b0;
        cap_beat = beat_q;
        mismatch = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (rise) begin
                    cap_en   = 1'b1;
                    cap_beat = '0;
                end
            end
            ST_PAIR1, ST_PAIR2: begin
                cap_en = 1'b1;
                if (rise) begin
                    cap_half = 1'b0;
                    cap_beat = '0;
                end else if (fall) begin
                    cap_half = 1'b1;
                    cap_beat = '0;
                end else begin
                    cap_half = (state_q == ST_PAIR2);
                    cap_beat = beat_q;
                    mismatch = (level != (state_q == ST_PAIR1));
                end
            end
            default: cap_en = 1'b0;
        endcase
    end

    // Next state: lock, resync, advance, half-wrap, group-wrap
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        if (cap_en) begin
            if (cap_beat == BEAT_W'(BEATS - 1)) begin
                state_d = cap_half ? ST_PAIR1 : ST_PAIR2;
                beat_d  = '0;
            end else begin
                state_d = cap_half ? ST_PAIR2 : ST_PAIR1;
                beat_d  = cap_beat + 1'b1;
            end
        end else if (state_q != ST_HUNT) begin
            state_d = ST_HUNT;
            beat_d  = '0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_HUNT;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | mismatch;
    end

    always_comb begin
        cap_slot  = {cap_half, cap_beat};
        align_err = err_q;
    end
endmodule

// File: rtl/iqdf_slice_store.sv
module iqdf_slice_store
    import iqdf_pkg::*;
#(
    parameter int SLICE_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  logic                 cap_en,
    input  logic [SLOT_W-1:0]    cap_slot,
    input  logic [SLICE_W-1:0]   slice_in,
    output logic                 fire,
    output logic [2*SLICE_W-1:0] i1_n,
    output logic [2*SLICE_W-1:0] q1_n,
    output logic [2*SLICE_W-1:0] i2_n,
    output logic [2*SLICE_W-1:0] q2_n
);
    logic [SLICE_W-1:0] slice_q [SLOTS];
    logic [SLICE_W-1:0] slice_n [SLOTS];
    logic [SLOTS-1:0]   mask_q, mask_n, hit;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_comb begin
            hit[k]     = cap_en && (cap_slot == SLOT_W'(k));
            slice_n[k] = hit[k] ? slice_in : slice_q[k];
            mask_n[k]  = (restart ? 1'b0 : mask_q[k]) | hit[k];
        end
        always_ff @(posedge clk or posedge rst) begin
            if (rst) slice_q[k] <= '0;
            else     slice_q[k] <= slice_n[k];
        end
    end

    always_comb begin
        fire = hit[SLOTS-1] && (&mask_n);
        // slot order inside a half: I high, Q high, I low, Q low
        i1_n = {slice_n[0], slice_n[2]};
        q1_n = {slice_n[1], slice_n[3]};
        i2_n = {slice_n[4], slice_n[6]};
        q2_n = {slice_n[5], slice_n[7]};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       mask_q <= '0;
        else if (fire) mask_q <= '0;
        else           mask_q <= mask_n;
    end
endmodule

// File: rtl/iqdf_out_stage.sv
module iqdf_out_stage #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic [SAMPLE_W-1:0] i1_n,
    input  logic [SAMPLE_W-1:0] q1_n,
    input  logic [SAMPLE_W-1:0] i2_n,
    input  logic [SAMPLE_W-1:0] q2_n,
    output logic [SAMPLE_W-1:0] i1_q,
    output logic [SAMPLE_W-1:0] q1_q,
    output logic [SAMPLE_W-1:0] i2_q,
    output logic [SAMPLE_W-1:0] q2_q,
    output logic                valid_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            valid_q <= 1'b0;
            i1_q    <= '0;
            q1_q    <= '0;
            i2_q    <= '0;
            q2_q    <= '0;
        end else begin
            valid_q <= fire;
            if (fire) begin
                i1_q <= i1_n;
                q1_q <= q1_n;
                i2_q <= i2_n;
                q2_q <= q2_n;
            end
        end
    end
endmodule

// File: rtl/iq_deframer_dual.sv
module iq_deframer_dual
    import iqdf_pkg::*;
#(
    parameter int SLICE_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLICE_W-1:0]   lane_slice,
    input  logic                 frame_bit,
    output logic [2*SLICE_W-1:0] i1_out,
    output logic [2*SLICE_W-1:0] q1_out,
    output logic [2*SLICE_W-1:0] i2_out,
    output logic [2*SLICE_W-1:0] q2_out,
    output logic                 grp_valid,
    output logic                 align_err
);
    localparam int SAMPLE_W = 2 * SLICE_W;

    logic              rise, fall, cap_en, fire;
    logic [SLOT_W-1:0] cap_slot;
    logic [SAMPLE_W-1:0] i1_n, q1_n, i2_n, q2_n;

    iqdf_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .frame_in (frame_bit),
        .rise     (rise),
        .fall     (fall)
    );

    iqdf_slot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .fall      (fall),
        .level     (frame_bit),
        .cap_en    (cap_en),
        .cap_slot  (cap_slot),
        .align_err (align_err)
    );

    iqdf_slice_store #(.SLICE_W(SLICE_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .restart  (rise),
        .cap_en   (cap_en),
        .cap_slot (cap_slot),
        .slice_in (lane_slice),
        .fire     (fire),
        .i1_n     (i1_n),
        .q1_n     (q1_n),
        .i2_n     (i2_n),
        .q2_n     (q2_n)
    );

    iqdf_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .i1_n    (i1_n),
        .q1_n    (q1_n),
        .i2_n    (i2_n),
        .q2_n    (q2_n),
        .i1_q    (i1_out),
        .q1_q    (q1_out),
        .i2_q    (i2_out),
        .q2_q    (q2_out),
        .valid_q (grp_valid)
    );
endmodule

// File: rtl/iqdf_checker.sv
module iqdf_checker #(
    parameter int SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_bit,
    input logic [SAMPLE_W-1:0] i1_out,
    input logic [SAMPLE_W-1:0] q1_out,
    input logic [SAMPLE_W-1:0] i2_out,
    input logic [SAMPLE_W-1:0] q2_out,
    input logic                grp_valid,
    input logic                align_err
);
    logic prev_f, seen_rise;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            prev_f    <= 1'b1;
            seen_rise <= 1'b0;
        end else begin
            prev_f <= frame_bit;
            if (frame_bit && !prev_f) seen_rise <= 1'b1;
        end
    end

    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        grp_valid |=> !grp_valid);

    a_r5_hold_pair1: assert property (@(posedge clk) disable iff (rst)
        !grp_valid |-> ($stable(i1_out) && $stable(q1_out)));

    a_r5_hold_pair2: assert property (@(posedge clk) disable iff (rst)
        !grp_valid |-> ($stable(i2_out) && $stable(q2_out)));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        align_err |=> align_err);

    a_r9_no_valid_before_rise: assert property (@(posedge clk) disable iff (rst)
        grp_valid |-> seen_rise);
endmodule

bind iq_deframer_dual iqdf_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .frame_bit (frame_bit),
    .i1_out    (i1_out),
    .q1_out    (q1_out),
    .i2_out    (i2_out),
    .q2_out    (q2_out),
    .grp_valid (grp_valid),
    .align_err (align_err)
);

// File: tb/iq_deframer_dual_tb_top.sv
module iq_deframer_dual_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 5;
    // each entry {I1, Q1, I2, Q2}: stimulus and expected output alike
    localparam logic [47:0] VEC [NV] = '{
        48'hABC_123_FED_456,
        48'h000_FFF_FFF_000,
        48'h800_001_7FF_FFE,
        48'h555_AAA_0F0_F0F,
        48'h3C3_C3C_9A5_5A9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  lane_slice = '0;
    logic        frame_bit = 1'b0;
    logic [11:0] i1_out, q1_out, i2_out, q2_out;
    logic        grp_valid, align_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // snapshot of outputs taken at each negedge before driving
    logic        s_valid, s_err;
    logic [47:0] s_out;
    // snapshot at first word of a group, and flags over the rest
    logic        f_valid, f_err;
    logic [47:0] f_out;
    bit          inner_valid, inner_moved;
    int          valid_seen;

    always #(CLK_P/2) clk = ~clk;

    iq_deframer_dual dut_i (
        .clk        (clk),
        .rst        (rst),
        .lane_slice (lane_slice),
        .frame_bit  (frame_bit),
        .i1_out     (i1_out),
        .q1_out     (q1_out),
        .i2_out     (i2_out),
        .q2_out     (q2_out),
        .grp_valid  (grp_valid),
        .align_err  (align_err)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    function automatic logic [5:0] slice_of(input logic [47:0] v, input int w);
        case (w)
            0: return v[47:42];
            1: return v[35:30];
            2: return v[41:36];
            3: return v[29:24];
            4: return v[23:18];
            5: return v[11:6];
            6: return v[17:12];
            default: return v[5:0];
        endcase
    endfunction

    task automatic snap();
        s_valid = grp_valid;
        s_err   = align_err;
        s_out   = {i1_out, q1_out, i2_out, q2_out};
        if (grp_valid) valid_seen++;
    endtask

    task automatic put(input logic f, input logic [5:0] d);
        @(negedge clk);
        snap();
        frame_bit  = f;
        lane_slice = d;
    endtask

    task automatic tick();
        @(negedge clk);
        snap();
    endtask

    task automatic send_group(input logic [47:0] v, input bit extra_hi, input bit drop_w3);
        inner_valid = 1'b0;
        inner_moved = 1'b0;
        for (int w = 0; w < 8; w++) begin
            if (!(drop_w3 && w == 3)) begin
                put(w < 4, slice_of(v, w));
                if (w == 0) begin
                    f_valid = s_valid; f_err = s_err; f_out = s_out;
                end else begin
                    if (s_valid) inner_valid = 1'b1;
                    if (s_out != f_out) inner_moved = 1'b1;
                end
            end
            if (extra_hi && w == 3) put(1'b1, 6'h2A);
        end
    endtask

    task automatic do_reset(input logic f_at_release);
        @(negedge clk);
        rst = 1'b1; frame_bit = 1'b0; lane_slice = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; frame_bit = f_at_release;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        snap();
        chk(s_out == 48'h0, "R9 outputs cleared in reset", s_out, 48'h0);
        chk(s_valid == 1'b0 && s_err == 1'b0, "R9 valid/err cleared in reset",
            {46'h0, s_valid, s_err}, 48'h0);
        rst = 1'b0; frame_bit = 1'b1;

        // R9: high level at release and following low words are discarded
        valid_seen = 0;
        for (int k = 0; k < 3; k++) put(1'b1, 6'(k + 5));
        for (int k = 0; k < 4; k++) put(1'b0, 6'(k + 9));
        tick();
        chk(valid_seen == 0, "R9 no valid before rising edge", 48'(valid_seen), 48'h0);
        chk(s_out == 48'h0, "R9 outputs untouched before rising edge", s_out, 48'h0);
        chk(s_err == 1'b0, "R9 no error while hunting", 48'(s_err), 48'h0);

        // Table walk: R1 R2 R3 R4 R5
        for (int g = 0; g <= NV; g++) begin
            send_group(VEC[g % NV], 1'b0, 1'b0);
            if (g > 0) begin
                chk(f_valid == 1'b1, "R4 valid after eighth slice", 48'(f_valid), 48'h1);
                chk(f_out[47:24] == VEC[g-1][47:24], "R1 R3 pair1 reassembly",
                    f_out, VEC[g-1]);
                chk(f_out[23:0] == VEC[g-1][23:0], "R2 R3 pair2 reassembly",
                    f_out, VEC[g-1]);
            end
            chk(inner_valid == 1'b0, "R4 single-cycle valid", 48'(inner_valid), 48'h0);
            chk(inner_moved == 1'b0, "R5 outputs hold between strobes", 48'(inner_moved), 48'h0);
        end
        chk(s_err == 1'b0, "R8 clean stream leaves error low", 48'(s_err), 48'h0);

        // R6 R8: extra high word, then recovery
        do_reset(1'b0);
        send_group(VEC[1], 1'b0, 1'b0);
        send_group(VEC[2], 1'b1, 1'b0);
        chk(f_valid && f_out == VEC[1], "R6 group before slip", f_out, VEC[1]);
        send_group(VEC[3], 1'b0, 1'b0);
        chk(f_valid == 1'b1, "R6 valid after extra word", 48'(f_valid), 48'h1);
        chk(f_out == VEC[2], "R6 resync gives correct group", f_out, VEC[2]);
        chk(f_err == 1'b1, "R8 mismatch sets error", 48'(f_err), 48'h1);
        send_group(VEC[4], 1'b0, 1'b0);
        chk(f_valid && f_out == VEC[3], "R6 following group intact", f_out, VEC[3]);
        chk(f_err == 1'b1, "R8 error stays set", 48'(f_err), 48'h1);

        // R7 R8: missing slice, edges alone do not flag error
        do_reset(1'b0);
        send_group(VEC[0], 1'b0, 1'b0);
        send_group(VEC[3], 1'b0, 1'b1);
        chk(f_valid && f_out == VEC[0], "R7 full group before short one", f_out, VEC[0]);
        send_group(VEC[4], 1'b0, 1'b0);
        chk(f_valid == 1'b0, "R7 short group gives no valid", 48'(f_valid), 48'h0);
        chk(inner_valid == 1'b0, "R7 no late valid for short group", 48'(inner_valid), 48'h0);
        chk(f_out == VEC[0], "R7 outputs keep previous group", f_out, VEC[0]);
        chk(f_err == 1'b0, "R8 edge resync does not set error", 48'(f_err), 48'h0);
        tick();
        chk(s_valid && s_out == VEC[4], "R6 rising edge restarts at slot 0", s_out, VEC[4]);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule